// File: doc/BRIEF.md
# USB Endpoint-Zero Control Handler

This block is the device-side logic for the control endpoint of a USB peripheral. On one side it faces a packet-level transaction interface. The host token arrives as a one-cycle pulse with a kind code, payload bytes stream one per cycle, and an end marker closes each host packet. The block answers every transaction with a handshake code and, for IN tokens, with a byte stream of its own. On the other side it presents a small CPU register port: a control/status register, a received-byte count, a byte-wide FIFO window and one level interrupt line.

Firmware runs each control request packet by packet. It reads the 8-byte command from the FIFO and acknowledges it by writing the serviced bit. It then either drains received data packets or loads outgoing ones and marks each with transmit-ready, and it flags the final packet with data-end. The block keeps track of which phase the transfer is in. It answers with NAK while the CPU still owes an action, and it sends STALL when firmware requests one or when the host pushes data past the declared end. It confirms the status stage with a final interrupt. A single 64-byte buffer serves both directions.

The transfer phase machine has five states:
- X_IDLE: no request is open.
- X_CMD: a command has been received and no data stage has started.
- X_DOUT: the data stage runs host to device.
- X_DIN: the data stage runs device to host.
- X_STATUS: data-end has been declared and the status stage is awaited.

Its transitions are:
- X_IDLE/X_CMD/X_DOUT/X_DIN/X_STATUS → X_CMD on a SETUP token.
- X_CMD/X_DOUT → X_DOUT when an OUT packet is stored.
- X_CMD/X_DIN → X_DIN when a packet is sent without data-end.
- X_CMD/X_DIN → X_STATUS when the last packet is sent.
- X_CMD/X_DOUT → X_STATUS when serviced and data-end are written together.
- X_STATUS → X_IDLE when the status stage completes or a late data packet is stalled.
- any → X_IDLE when a requested stall is sent.

A link machine (L_WAIT, L_RX, L_TX) tracks the packet currently on the wire.

Top module: `ep0_ctrl`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00, the count register (address 1) reads 0, and irq is low.
- R2: A SETUP token (h_tok code 0) followed by 8 bytes and h_pkt_end gets the reply ACK (d_hs code 0). The control/status register then reads 0x01: bit 0 is receive-ready. The count reads 8, irq is high, and FIFO reads (address 2) return the 8 bytes in arrival order.
- R3: An OUT token (code 1) while bit 0 is set is answered NAK (code 1) and leaves the count, the FIFO and irq unchanged. An IN token (code 2) before bit 1 (transmit-ready) is set is also answered NAK.
- R4: Writing bit 6 (serviced) clears bit 0 and empties the FIFO, so an empty FIFO read returns 0. Writing bit 6 together with bit 3 sets data-end (bit 3).
- R5: During a host-to-device data stage, a stored OUT packet of n bytes gets ACK, sets bit 0, loads n into the count register and raises irq.
- R6: Writing bit 1 arms transmit. The next IN token is answered DATA (code 3) on the following cycle. The FIFO bytes then leave one per cycle on d_byte, and d_pkt_end pulses the cycle after the last byte. Bit 1 clears and irq rises.
- R7: When bit 1 is written together with bit 3, the control/status register reads 0x08 after the packet is sent. A zero-length OUT status packet then gets ACK, clears bit 3 and raises irq.
- R8: After serviced and data-end are written with no data stage, an IN status token gets DATA with zero bytes (d_pkt_end on the next cycle), irq rises, and the register reads 0x00.
- R9: With bit 5 (stall request) set, the next OUT or IN transaction is answered STALL (code 2). Bit 2 (stall sent) sets, bit 5 clears and irq rises.
- R10: After data-end, a further packet in the data direction (a non-empty OUT after an OUT stage or a zero-data request, or another IN after an IN stage) is answered STALL. Bit 2 sets, bit 3 clears and irq rises.
- R11: Writing 0 to bit 2 clears it. Writing 1 to bit 2 leaves it set.
- R12: A SETUP token aborts any open phase. It clears the stall request, transmit-ready and data-end, and returns the block to the command phase.
- R13: A read of the control/status register clears irq.
- R14: At most 64 bytes of an OUT packet are stored, and the count register saturates at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_tok_vld | input | 1 | Host token pulse |
| h_tok | input | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN |
| h_byte_vld | input | 1 | Host payload byte valid |
| h_byte | input | 8 | Host payload byte |
| h_pkt_end | input | 1 | End of host packet, the cycle after its last byte |
| d_hs_vld | output | 1 | Device reply valid |
| d_hs | output | 2 | Reply: 0 ACK, 1 NAK, 2 STALL, 3 DATA |
| d_byte_vld | output | 1 | Device payload byte valid |
| d_byte | output | 8 | Device payload byte |
| d_pkt_end | output | 1 | End of device packet |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (pops the FIFO, clears irq on the status register) |
| cpu_addr | input | 2 | 0 control/status, 1 count, 2 FIFO |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| irq | output | 1 | Endpoint interrupt, level |

## Verification
The reply to a SETUP or OUT packet appears one cycle after the edge that samples h_pkt_end. The reply to an IN token appears one cycle after the token edge. Transmitted bytes follow on consecutive cycles, and d_pkt_end comes the cycle after the final byte. Register and irq updates are visible in the cycle after the causing edge, and CPU read data is combinational in the strobe cycle. The driver queues each expected reply, byte and end marker before it presents the stimulus, and a monitor compares them in order at each falling edge. Register checks run only after a settle interval that exceeds every latency above, and each settle interval first confirms that the scoreboard queue has drained.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2
    } tok_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_DATA  = 2'd3
    } hs_e;

    typedef enum logic [2:0] {
        X_IDLE,
        X_CMD,
        X_DOUT,
        X_DIN,
        X_STATUS
    } xfer_e;

    typedef enum logic [1:0] {
        L_WAIT,
        L_RX,
        L_TX
    } link_e;

    typedef enum logic [2:0] {
        RM_SETUP,
        RM_STORE,
        RM_NAK,
        RM_STALL,
        RM_STATUS
    } rxm_e;

    localparam int B_RXRDY   = 0;
    localparam int B_TXRDY   = 1;
    localparam int B_SENT    = 2;
    localparam int B_DEND    = 3;
    localparam int B_STALLRQ = 5;
    localparam int B_SERV    = 6;

    localparam logic [1:0] A_CSR  = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_FIFO = 2'd2;

endpackage

// File: rtl/ep0_fifo.sv
module ep0_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (level < LW'(DEPTH));
    assign do_pop  = pop && (level != '0);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            if (do_push && !do_pop)      level <= level + LW'(1);
            else if (do_pop && !do_push) level <= level - LW'(1);
        end
    end

endmodule

// File: rtl/ep0_fsm.sv
module ep0_fsm
    import ep0_pkg::*;
#(
    parameter int MPS = 64,
    localparam int LW = $clog2(MPS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_tok_vld,
    input  logic [1:0]    h_tok,
    input  logic          h_byte_vld,
    input  logic [7:0]    h_byte,
    input  logic          h_pkt_end,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [1:0]    cpu_addr,
    input  logic [7:0]    cpu_wdata,
    input  logic [7:0]    fifo_head,
    input  logic [LW-1:0] fifo_level,
    output logic          fifo_flush,
    output logic          fifo_push,
    output logic [7:0]    fifo_wdata,
    output logic          fifo_pop,
    output logic          d_hs_vld,
    output logic [1:0]    d_hs,
    output logic          d_byte_vld,
    output logic [7:0]    d_byte,
    output logic          d_pkt_end,
    output logic          irq,
    output logic [7:0]    csr_v,
    output logic [LW-1:0] count_q
);

    xfer_e         xfer_q, xfer_d;
    link_e         link_q, link_d;
    rxm_e          rxm_q, out_mode;
    hs_e           in_hs, rx_hs;
    logic [LW-1:0] rx_cnt, tx_left;
    logic          rx_any, tx_status, in_zlp;
    logic          rxrdy, txrdy, sent, dend, stallrq, last_in;

    logic ev_setup, ev_out, ev_in, ev_rx_end, ev_tx_end;
    logic csr_wr, serv_wr, store_byte;
    logic wdata_unused;

    assign wdata_unused = ^{cpu_wdata[7], cpu_wdata[4], cpu_wdata[0]};

    assign ev_setup  = h_tok_vld && (h_tok == TK_SETUP);
    assign ev_out    = h_tok_vld && (h_tok == TK_OUT);
    assign ev_in     = h_tok_vld && (h_tok == TK_IN);
    assign ev_rx_end = (link_q == L_RX) && h_pkt_end;
    assign ev_tx_end = (link_q == L_TX) && (tx_left == '0);
    assign csr_wr    = cpu_wr && (cpu_addr == A_CSR);
    assign serv_wr   = csr_wr && cpu_wdata[B_SERV];

    assign store_byte = (link_q == L_RX) && h_byte_vld
                        && (rxm_q == RM_SETUP || rxm_q == RM_STORE)
                        && (rx_cnt < LW'(MPS));

    assign fifo_push  = store_byte
                        || (cpu_wr && cpu_addr == A_FIFO && !txrdy && link_q != L_RX);
    assign fifo_wdata = store_byte ? h_byte : cpu_wdata;
    assign fifo_pop   = ((link_q == L_TX) && (tx_left != '0))
                        || (cpu_rd && cpu_addr == A_FIFO && link_q != L_TX);
    assign fifo_flush = ev_setup || serv_wr || (ev_tx_end && !tx_status);

    assign csr_v = {1'b0, 1'b0, stallrq, 1'b0, dend, sent, txrdy, rxrdy};

    // Reply decisions for the three transaction kinds
    always_comb begin
        in_zlp = !stallrq && (xfer_q == X_STATUS) && !last_in;
        if (stallrq) begin
            in_hs = HS_STALL;
        end else begin
            unique case (xfer_q)
                X_STATUS:     in_hs = last_in ? HS_STALL : HS_DATA;
                X_CMD, X_DIN: in_hs = txrdy ? HS_DATA : HS_NAK;
                default:      in_hs = HS_NAK;
            endcase
        end

        if (stallrq) begin
            out_mode = RM_STALL;
        end else begin
            unique case (xfer_q)
                X_CMD, X_DOUT: out_mode = rxrdy ? RM_NAK : RM_STORE;
                X_STATUS:      out_mode = RM_STATUS;
                default:       out_mode = RM_NAK;
            endcase
        end

        unique case (rxm_q)
            RM_SETUP, RM_STORE: rx_hs = HS_ACK;
            RM_STALL:           rx_hs = HS_STALL;
            RM_STATUS:          rx_hs = (last_in && !rx_any) ? HS_ACK : HS_STALL;
            default:            rx_hs = HS_NAK;
        endcase
    end

    // Next-state logic for transfer phase and link phase
    always_comb begin
        xfer_d = xfer_q;
        link_d = link_q;

        if (serv_wr && cpu_wdata[B_DEND] && (xfer_q == X_CMD || xfer_q == X_DOUT))
            xfer_d = X_STATUS;

        if (ev_rx_end) begin
            link_d = L_WAIT;
            unique case (rxm_q)
                RM_SETUP:            xfer_d = X_CMD;
                RM_STORE:            xfer_d = X_DOUT;
                RM_STALL, RM_STATUS: xfer_d = X_IDLE;
                default:             xfer_d = xfer_q;
            endcase
        end

        if (ev_tx_end) begin
            link_d = L_WAIT;
            if (tx_status) xfer_d = X_IDLE;
            else           xfer_d = dend ? X_STATUS : X_DIN;
        end

        if (ev_setup) begin
            xfer_d = X_CMD;
            link_d = L_RX;
        end else if (ev_out) begin
            link_d = L_RX;
        end else if (ev_in) begin
            if (in_hs == HS_DATA)       link_d = L_TX;
            else if (in_hs == HS_STALL) xfer_d = X_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q <= X_IDLE;
            link_q <= L_WAIT;
        end else begin
            xfer_q <= xfer_d;
            link_q <= link_d;
        end
    end

    // Register bits, counters and wire outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxm_q      <= RM_NAK;
            rx_cnt     <= '0;
            rx_any     <= 1'b0;
            tx_left    <= '0;
            tx_status  <= 1'b0;
            rxrdy      <= 1'b0;
            txrdy      <= 1'b0;
            sent       <= 1'b0;
            dend       <= 1'b0;
            stallrq    <= 1'b0;
            last_in    <= 1'b0;
            irq        <= 1'b0;
            count_q    <= '0;
            d_hs_vld   <= 1'b0;
            d_hs       <= HS_ACK;
            d_byte_vld <= 1'b0;
            d_byte     <= '0;
            d_pkt_end  <= 1'b0;
        end else begin
            d_hs_vld   <= 1'b0;
            d_byte_vld <= 1'b0;
            d_pkt_end  <= 1'b0;

            if (cpu_rd && cpu_addr == A_CSR) irq <= 1'b0;

            if (csr_wr) begin
                if (cpu_wdata[B_SERV])    rxrdy   <= 1'b0;
                if (cpu_wdata[B_TXRDY])   txrdy   <= 1'b1;
                if (cpu_wdata[B_DEND] && (cpu_wdata[B_SERV] || cpu_wdata[B_TXRDY]))
                    dend <= 1'b1;
                if (cpu_wdata[B_STALLRQ]) stallrq <= 1'b1;
                if (!cpu_wdata[B_SENT])   sent    <= 1'b0;
            end

            if (link_q == L_RX && h_byte_vld) begin
                rx_any <= 1'b1;
                if (rx_cnt < LW'(MPS)) rx_cnt <= rx_cnt + LW'(1);
            end

            if (ev_rx_end) begin
                d_hs_vld <= 1'b1;
                d_hs     <= rx_hs;
                unique case (rxm_q)
                    RM_SETUP, RM_STORE: begin
                        rxrdy   <= 1'b1;
                        count_q <= rx_cnt;
                        irq     <= 1'b1;
                    end
                    RM_STALL: begin
                        sent    <= 1'b1;
                        stallrq <= 1'b0;
                        irq     <= 1'b1;
                    end
                    RM_STATUS: begin
                        irq  <= 1'b1;
                        dend <= 1'b0;
                        if (rx_hs == HS_STALL) sent <= 1'b1;
                    end
                    default: ;
                endcase
            end

            if (link_q == L_TX) begin
                if (tx_left != '0) begin
                    d_byte_vld <= 1'b1;
                    d_byte     <= fifo_head;
                    tx_left    <= tx_left - LW'(1);
                end else begin
                    d_pkt_end <= 1'b1;
                    irq       <= 1'b1;
                    if (tx_status) begin
                        dend <= 1'b0;
                    end else begin
                        txrdy   <= 1'b0;
                        last_in <= 1'b1;
                    end
                end
            end

            if (ev_setup) begin
                rxm_q   <= RM_SETUP;
                rx_cnt  <= '0;
                rx_any  <= 1'b0;
                stallrq <= 1'b0;
                dend    <= 1'b0;
                txrdy   <= 1'b0;
                rxrdy   <= 1'b0;
                last_in <= 1'b0;
            end else if (ev_out) begin
                rxm_q  <= out_mode;
                rx_cnt <= '0;
                rx_any <= 1'b0;
            end else if (ev_in) begin
                d_hs_vld <= 1'b1;
                d_hs     <= in_hs;
                if (in_hs == HS_STALL) begin
                    sent    <= 1'b1;
                    stallrq <= 1'b0;
                    dend    <= 1'b0;
                    irq     <= 1'b1;
                end else if (in_hs == HS_DATA) begin
                    tx_left   <= in_zlp ? '0 : fifo_level;
                    tx_status <= in_zlp;
                end
            end
        end
    end

endmodule

// File: rtl/ep0_ctrl.sv
module ep0_ctrl
    import ep0_pkg::*;
#(
    parameter int MPS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_tok_vld,
    input  logic [1:0] h_tok,
    input  logic       h_byte_vld,
    input  logic [7:0] h_byte,
    input  logic       h_pkt_end,
    output logic       d_hs_vld,
    output logic [1:0] d_hs,
    output logic       d_byte_vld,
    output logic [7:0] d_byte,
    output logic       d_pkt_end,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [1:0] cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       irq
);

    localparam int LW = $clog2(MPS) + 1;

    logic          f_flush, f_push, f_pop;
    logic [7:0]    f_wdata, f_head;
    logic [LW-1:0] f_level, count_q;
    logic [7:0]    csr_v, cnt_view;

    assign cnt_view = 8'(count_q);

    ep0_fifo #(.DEPTH(MPS), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (f_flush),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .head  (f_head),
        .level (f_level)
    );

    ep0_fsm #(.MPS(MPS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_tok_vld  (h_tok_vld),
        .h_tok      (h_tok),
        .h_byte_vld (h_byte_vld),
        .h_byte     (h_byte),
        .h_pkt_end  (h_pkt_end),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .fifo_head  (f_head),
        .fifo_level (f_level),
        .fifo_flush (f_flush),
        .fifo_push  (f_push),
        .fifo_wdata (f_wdata),
        .fifo_pop   (f_pop),
        .d_hs_vld   (d_hs_vld),
        .d_hs       (d_hs),
        .d_byte_vld (d_byte_vld),
        .d_byte     (d_byte),
        .d_pkt_end  (d_pkt_end),
        .irq        (irq),
        .csr_v      (csr_v),
        .count_q    (count_q)
    );

    always_comb begin
        unique case (cpu_addr)
            A_CSR:   cpu_rdata = csr_v;
            A_CNT:   cpu_rdata = cnt_view;
            A_FIFO:  cpu_rdata = (f_level != '0) ? f_head : 8'h00;
            default: cpu_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/ep0_ctrl_chk.sv
module ep0_ctrl_chk #(
    parameter int MPS = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       d_hs_vld,
    input logic [1:0] d_hs,
    input logic       d_byte_vld,
    input logic       d_pkt_end,
    input logic       irq,
    input logic [7:0] csr_v,
    input logic [7:0] cnt_view
);

    p_ack_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hs_vld && d_hs == 2'd0) |-> irq);

    p_nak_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hs_vld && d_hs == 2'd1) |-> $stable(cnt_view));

    p_data_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hs_vld && d_hs == 2'd3) |=> (d_byte_vld || d_pkt_end));

    p_byte_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        d_byte_vld |=> (d_byte_vld || d_pkt_end));

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_hs_vld && d_byte_vld));

    p_end_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        d_pkt_end |-> irq);

    p_stall_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hs_vld && d_hs == 2'd2) |-> (csr_v[2] && !csr_v[5]));

    p_cnt_cap_r14: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_view <= 8'(MPS));

endmodule

bind ep0_ctrl ep0_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_hs_vld   (d_hs_vld),
    .d_hs       (d_hs),
    .d_byte_vld (d_byte_vld),
    .d_pkt_end  (d_pkt_end),
    .irq        (irq),
    .csr_v      (csr_v),
    .cnt_view   (cnt_view)
);

// File: tb/sim_ep0_ctrl.sv
module sim_ep0_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_tok_vld = 1'b0;
    logic [1:0] h_tok = 2'd0;
    logic       h_byte_vld = 1'b0;
    logic [7:0] h_byte = 8'd0;
    logic       h_pkt_end = 1'b0;
    logic       d_hs_vld, d_byte_vld, d_pkt_end, irq;
    logic [1:0] d_hs;
    logic [7:0] d_byte, cpu_rdata;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int    qk[$];
    int    qv[$];
    string qr[$];

    always #4 clk = ~clk;

    ep0_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .h_tok_vld(h_tok_vld), .h_tok(h_tok), .h_byte_vld(h_byte_vld),
        .h_byte(h_byte), .h_pkt_end(h_pkt_end),
        .d_hs_vld(d_hs_vld), .d_hs(d_hs), .d_byte_vld(d_byte_vld),
        .d_byte(d_byte), .d_pkt_end(d_pkt_end),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
    );

    task automatic check_eq(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
        end
    endtask

    // kinds: 0 handshake, 1 byte, 2 end marker
    task automatic expect_item(input int k, input int v, input string r);
        qk.push_back(k);
        qv.push_back(v);
        qr.push_back(r);
    endtask

    task automatic pop_cmp(input int k, input int v);
        int ek, ev;
        string er;
        checks++;
        if (qk.size() == 0) begin
            errors++;
            $display("FAIL unscheduled output kind=%0d actual=0x%0h expected=none", k, v);
        end else begin
            ek = qk.pop_front();
            ev = qv.pop_front();
            er = qr.pop_front();
            if (ek != k || ev != v) begin
                errors++;
                $display("FAIL %s actual=%0d/0x%0h expected=%0d/0x%0h", er, k, v, ek, ev);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (d_hs_vld)   pop_cmp(0, int'(d_hs));
            if (d_byte_vld) pop_cmp(1, int'(d_byte));
            if (d_pkt_end)  pop_cmp(2, 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(input string r, input int n);
        idle(n);
        check_eq({r, " queue drained"}, qk.size(), 0);
    endtask

    task automatic host_tok(input int t);
        @(negedge clk);
        h_tok_vld = 1'b1;
        h_tok     = 2'(t);
        @(negedge clk);
        h_tok_vld = 1'b0;
    endtask

    task automatic host_data(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            h_byte_vld = 1'b1;
            h_byte     = 8'(base + i);
            @(negedge clk);
        end
        h_byte_vld = 1'b0;
        h_pkt_end  = 1'b1;
        @(negedge clk);
        h_pkt_end  = 1'b0;
    endtask

    task automatic host_out(input int t, input int n, input int base);
        host_tok(t);
        host_data(n, base);
    endtask

    task automatic cpu_write(input int a, input int d);
        @(negedge clk);
        cpu_wr    = 1'b1;
        cpu_addr  = 2'(a);
        cpu_wdata = 8'(d);
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic cpu_read(input int a, output int v);
        @(negedge clk);
        cpu_rd   = 1'b1;
        cpu_addr = 2'(a);
        #1 v = int'(cpu_rdata);
        @(negedge clk);
        cpu_rd   = 1'b0;
    endtask

    task automatic read_check(input string r, input int a, input int exp);
        int v;
        cpu_read(a, v);
        check_eq(r, v, exp);
    endtask

    task automatic do_setup(input int base);
        expect_item(0, 0, "R2 setup ACK");
        host_out(0, 8, base);
        settle("R2", 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check_eq("R1 irq", int'(irq), 0);
        read_check("R1 csr", 0, 8'h00);
        read_check("R1 count", 1, 0);

        // R2 command packet
        do_setup(8'h10);
        check_eq("R2 irq", int'(irq), 1);
        read_check("R2 csr", 0, 8'h01);
        idle(1);
        check_eq("R13 irq cleared by csr read", int'(irq), 0);
        read_check("R2 count", 1, 8);
        for (int i = 0; i < 8; i++) read_check("R2 fifo byte", 2, 8'h10 + i);

        // R3 OUT while receive-ready still set
        expect_item(0, 1, "R3 OUT NAK");
        host_out(1, 3, 8'h50);
        settle("R3", 3);
        read_check("R3 count kept", 1, 8);
        check_eq("R3 irq unchanged", int'(irq), 0);

        // R4 serviced write
        cpu_write(0, 8'h40);
        read_check("R4 csr after serviced", 0, 8'h00);
        read_check("R4 fifo flushed", 2, 8'h00);

        // R5 data-out packet
        expect_item(0, 0, "R5 OUT ACK");
        host_out(1, 5, 8'h30);
        settle("R5", 3);
        check_eq("R5 irq", int'(irq), 1);
        read_check("R5 csr", 0, 8'h01);
        read_check("R5 count", 1, 5);
        for (int i = 0; i < 5; i++) read_check("R5 fifo byte", 2, 8'h30 + i);

        // R4 serviced with data-end
        cpu_write(0, 8'h48);
        read_check("R4 csr data end", 0, 8'h08);

        // R10 more OUT data after data-end
        expect_item(0, 2, "R10 OUT after data end STALL");
        host_out(1, 3, 8'h60);
        settle("R10", 3);
        check_eq("R10 irq", int'(irq), 1);
        read_check("R10 csr", 0, 8'h04);

        // R11 sent-stall clearing
        cpu_write(0, 8'h04);
        read_check("R11 write one keeps", 0, 8'h04);
        cpu_write(0, 8'h00);
        read_check("R11 write zero clears", 0, 8'h00);

        // R6 data-in packet
        do_setup(8'h20);
        cpu_write(0, 8'h40);
        for (int i = 0; i < 4; i++) cpu_write(2, 8'hA0 + i);
        expect_item(0, 1, "R3 IN NAK before transmit ready");
        host_tok(2);
        settle("R3", 3);
        cpu_write(0, 8'h02);
        read_check("R6 csr armed", 0, 8'h02);
        expect_item(0, 3, "R6 DATA reply");
        for (int i = 0; i < 4; i++) expect_item(1, 8'hA0 + i, "R6 tx byte");
        expect_item(2, 0, "R6 end marker");
        host_tok(2);
        settle("R6", 8);
        check_eq("R6 irq", int'(irq), 1);
        read_check("R6 csr after send", 0, 8'h00);

        // R7 last packet then status OUT
        cpu_write(2, 8'hB0);
        cpu_write(2, 8'hB1);
        cpu_write(0, 8'h0A);
        expect_item(0, 3, "R7 DATA reply");
        expect_item(1, 8'hB0, "R7 tx byte");
        expect_item(1, 8'hB1, "R7 tx byte");
        expect_item(2, 0, "R7 end marker");
        host_tok(2);
        settle("R7", 6);
        read_check("R7 csr data end pending", 0, 8'h08);
        expect_item(0, 0, "R7 status ACK");
        host_out(1, 0, 0);
        settle("R7", 3);
        check_eq("R7 irq", int'(irq), 1);
        read_check("R7 csr done", 0, 8'h00);

        // R8 zero-data request
        do_setup(8'h70);
        cpu_write(0, 8'h48);
        expect_item(0, 3, "R8 status DATA");
        expect_item(2, 0, "R8 zero-length end");
        host_tok(2);
        settle("R8", 4);
        check_eq("R8 irq", int'(irq), 1);
        read_check("R8 csr", 0, 8'h00);

        // R10 second IN after final packet
        do_setup(8'h78);
        cpu_write(0, 8'h40);
        cpu_write(2, 8'hC0);
        cpu_write(0, 8'h0A);
        expect_item(0, 3, "R10 DATA reply");
        expect_item(1, 8'hC0, "R10 tx byte");
        expect_item(2, 0, "R10 end marker");
        host_tok(2);
        settle("R10", 5);
        expect_item(0, 2, "R10 IN after data end STALL");
        host_tok(2);
        settle("R10", 3);
        read_check("R10 csr after IN stall", 0, 8'h04);
        cpu_write(0, 8'h00);

        // R9 requested stall
        do_setup(8'h80);
        cpu_write(0, 8'h60);
        read_check("R9 csr stall requested", 0, 8'h20);
        expect_item(0, 2, "R9 STALL");
        host_out(1, 2, 8'h90);
        settle("R9", 3);
        check_eq("R9 irq", int'(irq), 1);
        read_check("R9 csr", 0, 8'h04);
        cpu_write(0, 8'h00);

        // R12 SETUP aborts pending phase
        do_setup(8'h88);
        cpu_write(0, 8'h60);
        cpu_write(0, 8'h02);
        read_check("R12 csr before abort", 0, 8'h22);
        do_setup(8'h98);
        read_check("R12 csr after abort", 0, 8'h01);
        cpu_write(0, 8'h40);
        expect_item(0, 1, "R12 IN NAK in command phase");
        host_tok(2);
        settle("R12", 3);

        // R14 oversize OUT packet
        expect_item(0, 0, "R14 OUT ACK");
        host_out(1, 70, 0);
        settle("R14", 3);
        read_check("R14 count saturates", 1, 64);
        for (int i = 0; i < 64; i++) read_check("R14 fifo byte", 2, i);
        read_check("R14 fifo empty", 2, 0);

        idle(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule